// File: doc/BRIEF.md
# Real-mode far transfer sequencer

This block carries out the stack side of three real-mode control transfers for a 16-bit core: a far call, a far return that also releases a number of stack bytes, and a return from interrupt. The core presents the operation, its current CS, IP, ESP and FLAGS, the call target, the release count, the stack-size bit and the code-segment limit, then pulses `start`. The sequencer performs the pushes or pops one word at a time over a stack port with a ready handshake. It checks the new offset against the code-segment limit. It then reports the resulting CS, IP, ESP and FLAGS with a one-cycle `done`.

Stack pointer movement stays inside the sequencer until the transfer succeeds. If the limit check fails, `fault` rises together with `done` and every reported value equals the value captured at `start`. The core then raises a general-protection fault with error code 0. Stack addresses are byte offsets within the stack segment. Adding the segment base is the job of the caller.

Top module: `rm_far_seq`

## Requirements
- R1: After reset, `done`, `fault` and `mem_req` are 0 and `new_cs`, `new_ip`, `new_esp` and `new_flags` are all zero.
- R2: A call (op code 0) writes `cur_cs` to address SP-2 and then `cur_ip` to address SP-4. It then reports CS = `tgt_cs`, IP = `tgt_ip`, ESP = {upper half of `cur_esp`, SP-4} and FLAGS = `cur_flags`.
- R3: A call whose `tgt_ip` is greater than `cs_limit` makes no stack access and ends with `fault`=1. A target equal to the limit is accepted.
- R4: A far return (op code 1) reads IP from address SP and CS from SP+2, reports those two words, and leaves FLAGS unchanged.
- R5: After a successful far return, when `stk32`=1 the zero-extended `imm` is added to the full 32-bit value {upper ESP, SP+4}, so a carry reaches the upper half. When `stk32`=0 it is added to the low 16 bits only, with wraparound, and the upper half is preserved.
- R6: An interrupt return (op code 2) reads IP, CS and FLAGS from SP, SP+2 and SP+4 in that order. It reports all 16 popped flag bits and ESP = {upper ESP, SP+6}, and `imm` has no effect.
- R7: On a return whose popped IP is greater than `cs_limit`, `fault`=1 and CS, IP, ESP and FLAGS are reported equal to the values captured at `start`.
- R8: While `mem_req` is 1 and `mem_rdy` is 0, `mem_addr`, `mem_we` and `mem_wdata` hold. Exactly one word moves per cycle in which both are 1.
- R9: Each push lowers the 16-bit stack offset by 2 before the access, and each pop raises it by 2 after the access, both modulo 2^16.
- R10: `start` with op code 3 is ignored. `start` arriving while a transfer is in flight is ignored, and so are changes on the operand inputs after acceptance.
- R11: `done` is high for exactly one cycle per accepted transfer, and `fault` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| op | input | 2 | 0 call, 1 far return, 2 interrupt return, 3 none |
| tgt_cs | input | 16 | Call target selector |
| tgt_ip | input | 16 | Call target offset |
| cur_cs | input | 16 | Current CS selector |
| cur_ip | input | 16 | Current (return) IP |
| cur_esp | input | 32 | Current ESP |
| cur_flags | input | 16 | Current FLAGS |
| imm | input | 16 | Bytes released by a far return |
| stk32 | input | 1 | Stack-size bit: 1 selects 32-bit ESP for the release |
| cs_limit | input | 16 | Code-segment limit |
| mem_req | output | 1 | Stack access request |
| mem_we | output | 1 | 1 for a push, 0 for a pop |
| mem_addr | output | 16 | Stack byte offset of the access |
| mem_wdata | output | 16 | Word pushed |
| mem_rdata | input | 16 | Word popped |
| mem_rdy | input | 1 | Access completes in this cycle |
| new_cs | output | 16 | Resulting CS |
| new_ip | output | 16 | Resulting IP |
| new_esp | output | 32 | Resulting ESP |
| new_flags | output | 16 | Resulting FLAGS |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Limit violation, valid with done |

## Verification
A stray `start` can fall in the same cycle as a stack handshake of a transfer already in flight. The acceptance logic and the pointer stepping then compete for the same edge. The bench provokes this by raising `start`, with a random op code and scrambled operand inputs, on random busy cycles while `mem_rdy` is also random. It judges the outcome by requiring that the access order, the addresses and data on the stack port, and the reported results all match what the first, captured transfer alone predicts.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
  typedef enum logic [1:0] {
    OP_CALL = 2'd0,
    OP_RETF = 2'd1,
    OP_IRET = 2'd2,
    OP_NONE = 2'd3
  } fx_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHECK,
    S_PUSH_CS,
    S_PUSH_IP,
    S_POP_IP,
    S_POP_CS,
    S_POP_FL,
    S_COMMIT,
    S_FAULT
  } fx_state_e;
endpackage

// File: rtl/fxs_rst_sync.sv
module fxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fxs_ctrl.sv
module fxs_ctrl
  import fxs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic [1:0] op_i,
  input  logic      mem_rdy,
  input  logic      ip_ok,
  output fx_state_e state,
  output fx_op_e    op_q,
  output logic      accept,
  output logic      hs,
  output logic      mem_req,
  output logic      mem_we,
  output logic      done_q,
  output logic      fault_q
);
  fx_state_e state_d;
  fx_op_e    op_d;
  logic      done_d, fault_d;

  always_comb begin
    state_d = state;
    accept  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start && (fx_op_e'(op_i) != OP_NONE)) begin
          accept  = 1'b1;
          state_d = (fx_op_e'(op_i) == OP_CALL) ? S_CHECK : S_POP_IP;
        end
      end
      S_CHECK: begin
        if (!ip_ok)                 state_d = S_FAULT;
        else if (op_q == OP_CALL)   state_d = S_PUSH_CS;
        else                        state_d = S_COMMIT;
      end
      S_PUSH_CS: if (mem_rdy) state_d = S_PUSH_IP;
      S_PUSH_IP: if (mem_rdy) state_d = S_COMMIT;
      S_POP_IP:  if (mem_rdy) state_d = S_POP_CS;
      S_POP_CS:  if (mem_rdy) state_d = (op_q == OP_IRET) ? S_POP_FL : S_CHECK;
      S_POP_FL:  if (mem_rdy) state_d = S_CHECK;
      S_COMMIT:  state_d = S_IDLE;
      S_FAULT:   state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  assign mem_req = (state == S_PUSH_CS) || (state == S_PUSH_IP) ||
                   (state == S_POP_IP)  || (state == S_POP_CS)  || (state == S_POP_FL);
  assign mem_we  = (state == S_PUSH_CS) || (state == S_PUSH_IP);
  assign hs      = mem_req && mem_rdy;

  always_comb begin
    op_d    = accept ? fx_op_e'(op_i) : op_q;
    done_d  = (state == S_COMMIT) || (state == S_FAULT);
    fault_d = (state == S_FAULT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_CALL;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state   <= state_d;
      op_q    <= op_d;
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> done_q); // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R11
  AST_CS_BEFORE_IP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PUSH_IP) |-> ($past(state) == S_PUSH_CS || $past(state) == S_PUSH_IP)); // R2
endmodule

// File: rtl/fxs_data.sv
module fxs_data
  import fxs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ESP_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fx_state_e         state,
  input  fx_op_e            op_q,
  input  logic              accept,
  input  logic              hs,
  input  logic              mem_req,
  input  logic              mem_rdy,
  input  logic [WORD_W-1:0] tgt_cs,
  input  logic [WORD_W-1:0] tgt_ip,
  input  logic [WORD_W-1:0] cur_cs,
  input  logic [WORD_W-1:0] cur_ip,
  input  logic [ESP_W-1:0]  cur_esp,
  input  logic [WORD_W-1:0] cur_flags,
  input  logic [WORD_W-1:0] imm,
  input  logic              stk32,
  input  logic [WORD_W-1:0] cs_limit,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              ip_ok,
  output logic [WORD_W-1:0] new_cs,
  output logic [WORD_W-1:0] new_ip,
  output logic [ESP_W-1:0]  new_esp,
  output logic [WORD_W-1:0] new_flags
);
  localparam int              STEP_B = WORD_W / 8;
  localparam logic [WORD_W-1:0] STEP = WORD_W'(STEP_B);
  localparam int              HI_W   = ESP_W - WORD_W;

  logic [WORD_W-1:0] tcs_q, tip_q, imm_q, lim_q, ocs_q, oip_q, ofl_q;
  logic [ESP_W-1:0]  oesp_q;
  logic              stk_q;
  logic [WORD_W-1:0] sp_q, sp_d;
  logic [WORD_W-1:0] pip_q, pcs_q, pfl_q;
  logic              is_push;

  // operand capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcs_q <= '0; tip_q <= '0; imm_q <= '0; lim_q <= '0;
      ocs_q <= '0; oip_q <= '0; ofl_q <= '0; oesp_q <= '0; stk_q <= 1'b0;
    end else if (accept) begin
      tcs_q <= tgt_cs;  tip_q <= tgt_ip;  imm_q <= imm;  lim_q <= cs_limit;
      ocs_q <= cur_cs;  oip_q <= cur_ip;  ofl_q <= cur_flags;
      oesp_q <= cur_esp; stk_q <= stk32;
    end
  end

  // speculative stack offset
  assign is_push = (state == S_PUSH_CS) || (state == S_PUSH_IP);

  always_comb begin
    sp_d = sp_q;
    if (accept)             sp_d = cur_esp[WORD_W-1:0];
    else if (hs && is_push) sp_d = sp_q - STEP;
    else if (hs)            sp_d = sp_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  assign mem_addr  = is_push ? (sp_q - STEP) : sp_q;
  assign mem_wdata = (state == S_PUSH_CS) ? ocs_q : oip_q;

  // popped words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pip_q <= '0; pcs_q <= '0; pfl_q <= '0;
    end else if (hs) begin
      if (state == S_POP_IP) pip_q <= mem_rdata;
      if (state == S_POP_CS) pcs_q <= mem_rdata;
      if (state == S_POP_FL) pfl_q <= mem_rdata;
    end
  end

  assign ip_ok = ((op_q == OP_CALL) ? tip_q : pip_q) <= lim_q;

  // result values
  logic [ESP_W-1:0]  base_esp, fin_esp;
  logic [WORD_W-1:0] fin_cs, fin_ip, fin_fl;
  logic              ld_commit, ld_fault;

  always_comb begin
    base_esp = {oesp_q[ESP_W-1:WORD_W], sp_q};
    fin_esp  = base_esp;
    if (op_q == OP_RETF) begin
      if (stk_q) fin_esp = base_esp + {{HI_W{1'b0}}, imm_q};
      else       fin_esp = {oesp_q[ESP_W-1:WORD_W], sp_q + imm_q};
    end
    fin_cs = (op_q == OP_CALL) ? tcs_q : pcs_q;
    fin_ip = (op_q == OP_CALL) ? tip_q : pip_q;
    fin_fl = (op_q == OP_IRET) ? pfl_q : ofl_q;
  end

  assign ld_commit = (state == S_COMMIT);
  assign ld_fault  = (state == S_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_cs <= '0; new_ip <= '0; new_esp <= '0; new_flags <= '0;
    end else if (ld_commit) begin
      new_cs <= fin_cs; new_ip <= fin_ip; new_esp <= fin_esp; new_flags <= fin_fl;
    end else if (ld_fault) begin
      new_cs <= ocs_q; new_ip <= oip_q; new_esp <= oesp_q; new_flags <= ofl_q;
    end
  end

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> ($stable(mem_addr) && $stable(mem_wdata))); // R8
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && is_push) |=> (sp_q == $past(sp_q) - STEP)); // R9
  AST_NO_PUSH_OVER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && is_push) |-> (tip_q <= lim_q)); // R3
endmodule

// File: rtl/rm_far_seq.sv
module rm_far_seq
  import fxs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ESP_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [WORD_W-1:0] tgt_cs,
  input  logic [WORD_W-1:0] tgt_ip,
  input  logic [WORD_W-1:0] cur_cs,
  input  logic [WORD_W-1:0] cur_ip,
  input  logic [ESP_W-1:0]  cur_esp,
  input  logic [WORD_W-1:0] cur_flags,
  input  logic [WORD_W-1:0] imm,
  input  logic              stk32,
  input  logic [WORD_W-1:0] cs_limit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rdy,
  output logic [WORD_W-1:0] new_cs,
  output logic [WORD_W-1:0] new_ip,
  output logic [ESP_W-1:0]  new_esp,
  output logic [WORD_W-1:0] new_flags,
  output logic              done,
  output logic              fault
);
  logic      rst_s_n;
  fx_state_e state;
  fx_op_e    op_q;
  logic      accept, hs, ip_ok;

  fxs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  fxs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .start(start), .op_i(op), .mem_rdy(mem_rdy),
    .ip_ok(ip_ok), .state(state), .op_q(op_q), .accept(accept), .hs(hs),
    .mem_req(mem_req), .mem_we(mem_we), .done_q(done), .fault_q(fault)
  );

  fxs_data #(.WORD_W(WORD_W), .ESP_W(ESP_W)) u_data (
    .clk(clk), .rst_n(rst_s_n), .state(state), .op_q(op_q), .accept(accept),
    .hs(hs), .mem_req(mem_req), .mem_rdy(mem_rdy),
    .tgt_cs(tgt_cs), .tgt_ip(tgt_ip), .cur_cs(cur_cs), .cur_ip(cur_ip),
    .cur_esp(cur_esp), .cur_flags(cur_flags), .imm(imm), .stk32(stk32),
    .cs_limit(cs_limit), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .ip_ok(ip_ok), .new_cs(new_cs), .new_ip(new_ip),
    .new_esp(new_esp), .new_flags(new_flags)
  );

  AST_WRITE_ONLY_ON_CALL: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && mem_we) |-> (op_q == OP_CALL)); // R2
endmodule

// File: tb/rm_far_seq_bench.sv
`timescale 1ns/1ps
module rm_far_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [15:0] tgt_cs, tgt_ip, cur_cs, cur_ip, cur_flags, imm, cs_limit;
  logic [31:0] cur_esp;
  logic        stk32;
  logic        mem_req, mem_we, mem_rdy;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] new_cs, new_ip, new_flags;
  logic [31:0] new_esp;
  logic        done, fault;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rm_far_seq u_rm_far_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .tgt_cs(tgt_cs),
    .tgt_ip(tgt_ip), .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_esp(cur_esp),
    .cur_flags(cur_flags), .imm(imm), .stk32(stk32), .cs_limit(cs_limit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .new_cs(new_cs), .new_ip(new_ip), .new_esp(new_esp),
    .new_flags(new_flags), .done(done), .fault(fault)
  );

  logic [15:0] mem [0:255];
  logic        lg_we   [0:7];
  logic [15:0] lg_addr [0:7];
  logic [15:0] lg_data [0:7];
  int          n_acc;
  bit          poke_en;

  // expected values
  logic [15:0] x_cs, x_ip, x_fl;
  logic [31:0] x_esp;
  logic        x_fault;
  int          x_n;
  logic        x_we   [0:2];
  logic [15:0] x_addr [0:2];
  logic [15:0] x_data [0:2];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem[a[8:1]];
  endfunction

  task automatic predict();
    logic [15:0] sp, w0, w1, w2;
    sp = cur_esp[15:0];
    x_cs = cur_cs; x_ip = cur_ip; x_fl = cur_flags; x_esp = cur_esp;
    x_fault = 1'b0; x_n = 0;
    w0 = rd(sp); w1 = rd(sp + 16'd2); w2 = rd(sp + 16'd4);
    case (op)
      2'd0: begin
        if (tgt_ip > cs_limit) x_fault = 1'b1;
        else begin
          x_n = 2;
          x_we[0] = 1'b1; x_addr[0] = sp - 16'd2; x_data[0] = cur_cs;
          x_we[1] = 1'b1; x_addr[1] = sp - 16'd4; x_data[1] = cur_ip;
          x_cs = tgt_cs; x_ip = tgt_ip; x_esp = {cur_esp[31:16], sp - 16'd4};
        end
      end
      2'd1, 2'd2: begin
        x_n = (op == 2'd1) ? 2 : 3;
        x_we[0] = 1'b0; x_addr[0] = sp;          x_data[0] = w0;
        x_we[1] = 1'b0; x_addr[1] = sp + 16'd2;  x_data[1] = w1;
        x_we[2] = 1'b0; x_addr[2] = sp + 16'd4;  x_data[2] = w2;
        if (w0 > cs_limit) x_fault = 1'b1;
        else begin
          x_cs = w1; x_ip = w0;
          if (op == 2'd2) begin
            x_fl = w2; x_esp = {cur_esp[31:16], sp + 16'd6};
          end else if (stk32) begin
            x_esp = {cur_esp[31:16], sp + 16'd4} + {16'd0, imm};
          end else begin
            x_esp = {cur_esp[31:16], sp + 16'd4 + imm};
          end
        end
      end
      default: ;
    endcase
  endtask

  task automatic run_op(input string req);
    bit          got;
    bit          waitp;
    logic [15:0] wa, wd;
    logic        ww;
    predict();
    n_acc = 0; got = 0; waitp = 0; wa = '0; wd = '0; ww = 1'b0;
    start = 1'b1;
    for (int cyc = 0; cyc < 200 && !got; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin
        got = 1;
      end else begin
        if (waitp) begin
          check(mem_req && mem_addr == wa && mem_we == ww && (!ww || mem_wdata == wd),
                "R8", "held access", {mem_addr, mem_wdata}, {wa, wd});
        end
        if (poke_en && ($urandom % 3 == 0)) begin
          start = 1'b1; op = 2'($urandom); tgt_ip = 16'($urandom);
          cur_esp = $urandom; imm = 16'($urandom); cs_limit = 16'($urandom);
          cur_cs = 16'($urandom); cur_flags = 16'($urandom); stk32 = 1'($urandom);
        end
        mem_rdy = ($urandom % 4) != 0;
        if (mem_req) begin
          mem_rdata = rd(mem_addr);
          if (mem_rdy) begin
            if (n_acc < 8) begin
              lg_we[n_acc] = mem_we; lg_addr[n_acc] = mem_addr;
              lg_data[n_acc] = mem_we ? mem_wdata : mem_rdata;
            end
            n_acc++;
            if (mem_we) mem[mem_addr[8:1]] = mem_wdata;
          end
        end
        waitp = mem_req && !mem_rdy;
        wa = mem_addr; wd = mem_wdata; ww = mem_we;
      end
    end
    check(got, "R11", "done seen", 32'(got), 32'd1);
    check(fault == x_fault, x_fault ? ((op == 2'd0) ? "R3" : "R7") : req, "fault",
          32'(fault), 32'(x_fault));
    check(new_cs == x_cs, req, "new_cs", 32'(new_cs), 32'(x_cs));
    check(new_ip == x_ip, req, "new_ip", 32'(new_ip), 32'(x_ip));
    check(new_esp == x_esp, x_fault ? "R7" : req, "new_esp", new_esp, x_esp);
    check(new_flags == x_fl, req, "new_flags", 32'(new_flags), 32'(x_fl));
    check(n_acc == x_n, "R8", "access count", 32'(n_acc), 32'(x_n));
    for (int k = 0; k < x_n && k < n_acc; k++) begin
      check(lg_we[k] == x_we[k] && lg_addr[k] == x_addr[k] && lg_data[k] == x_data[k],
            req, "access order", {lg_addr[k], lg_data[k]}, {x_addr[k], x_data[k]});
    end
    @(negedge clk);
    check(!done && !fault, "R11", "done pulse width", {31'd0, done}, 32'd0);
  endtask

  task automatic set_ops(input logic [1:0] o, input logic [15:0] sp_lo,
                         input logic [15:0] lim);
    op = o; cur_esp = {16'($urandom), sp_lo}; cs_limit = lim;
    tgt_cs = 16'($urandom); tgt_ip = 16'($urandom); cur_cs = 16'($urandom);
    cur_ip = 16'($urandom); cur_flags = 16'($urandom); imm = 16'($urandom);
    stk32 = 1'($urandom);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    rst_n = 1'b0; start = 1'b0; mem_rdy = 1'b0; mem_rdata = '0; poke_en = 0;
    set_ops(2'd0, 16'h0100, 16'hFFFF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && !fault && !mem_req, "R1", "flags after reset",
          {29'd0, done, fault, mem_req}, 32'd0);
    check(new_cs == 0 && new_ip == 0 && new_esp == 0 && new_flags == 0, "R1",
          "outputs after reset", new_esp, 32'd0);

    // R2 call at limit exactly, R3 limit+1
    set_ops(2'd0, 16'h0200, 16'h4000); tgt_ip = 16'h4000; run_op("R2");
    set_ops(2'd0, 16'h0200, 16'h4000); tgt_ip = 16'h4001; run_op("R3");
    // R9 push wrap from zero
    set_ops(2'd0, 16'h0000, 16'hFFFF); run_op("R9");
    // R4 far return, 16-bit release wrap (R5)
    set_ops(2'd1, 16'hFFF0, 16'hFFFF); stk32 = 1'b0; imm = 16'h0020; run_op("R5");
    // R5 32-bit release with carry into upper half
    set_ops(2'd1, 16'hFFF0, 16'hFFFF); stk32 = 1'b1; imm = 16'h0020;
    cur_esp[31:16] = 16'h1234; run_op("R5");
    set_ops(2'd1, 16'h0300, 16'hFFFF); run_op("R4");
    // R6 interrupt return across the wrap point, imm has no effect
    set_ops(2'd2, 16'hFFFC, 16'hFFFF); imm = 16'hBEEF; run_op("R6");
    // R7 popped IP above limit
    set_ops(2'd2, 16'h0400, 16'h0010); mem[9'h400 >> 1] = 16'h0011; run_op("R7");
    set_ops(2'd1, 16'h0500, 16'h0010); mem[9'h500 >> 1] = 16'h0011; run_op("R7");

    // R10 op code 3 ignored
    begin
      logic [31:0] prev_esp;
      prev_esp = new_esp;
      set_ops(2'd3, 16'h0600, 16'hFFFF);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < 6; k++) begin
        check(!done && !mem_req, "R10", "op 3 idle", {30'd0, done, mem_req}, 32'd0);
        @(negedge clk);
      end
      check(new_esp == prev_esp, "R10", "op 3 esp", new_esp, prev_esp);
    end

    // R10 random with start pokes during busy, constrained random mix
    poke_en = 1;
    for (int i = 0; i < 60; i++) begin
      set_ops(2'($urandom % 3), {15'($urandom), 1'b0},
              ($urandom % 4 == 0) ? 16'($urandom) : 16'hF000 | 16'($urandom));
      case (op)
        2'd0:    run_op("R10");
        2'd1:    run_op("R4");
        default: run_op("R6");
      endcase
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule